// File: doc/BRIEF.md
# Serial audio frame sync generator

This block is the master-side timing source for the serial port of a stereo audio converter. It divides the master clock into a bit clock and a frame sync. It supports frames of 64 or 128 bit periods. Alongside the two clocks it reports which bit of the frame is in progress, whether that bit belongs to this device, and whether the bit lies in the left or the right word. Downstream serialisers use those flags to decide when to shift data.

A single select bit has two meanings. In 128-bit frames it chooses which half of the frame belongs to this device. In 64-bit frames the whole frame belongs to the device, so the bit chooses the sync waveform instead: either a one-bit pulse ahead of the data, or a level that is high for the left word and low for the right word. The configuration inputs are captured only while reset is held. When reset or power-down is released, the counters start again from the first bit of a new frame.

The pad drivers sit outside the block. They use the enable output to release the clock and sync pins during power-down, and they drive those pins from the data outputs at all other times.

Top module: `serial_frame_sync`

## Requirements
- R1: `bitIndex` counts 0 up to L-1 and then wraps to 0, where L is 128 when the captured `frameLong` is 1 and 64 when it is 0. It advances once per bit-clock period.
- R2: With K = 2*(`rateSel`+1), the bit-clock period is K master clocks in 128-bit frames and 2*K master clocks in 64-bit frames. This gives a sample rate of master clock / (256*(`rateSel`+1)). In each period `sclk` is low for the first half and high for the second half. `bitIndex` changes only at the master-clock edge where `sclk` falls.
- R3: In 128-bit frames `slotActive` is 1 exactly when `bitIndex`[6] equals the captured `slotSel`. With `slotSel`=0 this selects bits 0..63, and with `slotSel`=1 it selects bits 64..127.
- R4: In 64-bit frames `slotActive` is 1 on every bit of a running frame.
- R5: In the pulse format, `ssync` is 1 only during bit L-1, the bit period just before bit 0 of the next frame. The pulse format applies to all 128-bit frames and to 64-bit frames with `slotSel`=0.
- R6: In 64-bit frames with `slotSel`=1, `ssync` is 1 for bits 0..31 (the left word) and 0 for bits 32..63 (the right word).
- R7: While running, `wordRight` is 1 exactly when (`bitIndex` mod 64) >= 32.
- R8: While `rst`=1 and `powerDown`=0, `pinEnable`=1 and `sclk`, `ssync`, `slotActive` and `wordRight` are 0. `bitIndex` is 0 after one master-clock edge. After release, the first master-clock period shows bit 0 with `sclk` low.
- R9: While `powerDown`=1, `pinEnable`=0 and all timing outputs are 0, whatever the state of `rst`. After release, the frame restarts from bit 0 with the captured configuration.
- R10: `frameLong`, `slotSel` and `rateSel` are captured on master-clock edges while `rst`=1. Changes to them at any other time leave the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; also captures the configuration |
| powerDown | input | 1 | Power-down, active high; releases the pins |
| frameLong | input | 1 | 1: 128-bit frames, 0: 64-bit frames |
| slotSel | input | 1 | Sub-frame choice (128-bit) or sync format (64-bit) |
| rateSel | input | 3 | Sample-rate divider select |
| sclk | output | 1 | Bit clock |
| ssync | output | 1 | Frame sync |
| pinEnable | output | 1 | Drive enable for the bit-clock and sync pads |
| slotActive | output | 1 | Current bit belongs to this device |
| bitIndex | output | 7 | Bit position within the frame |
| wordRight | output | 1 | Current bit lies in the right word |

## Verification
The bench builds the block with its default parameters: a divider multiplier of 2 and a 3-bit rate select. With these values the longest frame is 2048 master clocks, so whole frames at the slowest and fastest rates fit comfortably in one run. The short periods at the fastest rate exercise a bit clock that is only two master clocks wide, where the fall of the clock and the bit advance coincide on every other edge. The two frame lengths, both slot choices and both sync formats are all reachable with these settings, and so are configuration changes made mid-frame and a power-down held together with reset.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int IDX_W     = 7;
  localparam int SUB_BITS  = 64;
  localparam int WORD_BITS = 32;

  typedef struct packed {
    logic run;        // outputs live, counters advancing
    logic clear;      // restart the frame
    logic bitTick;    // last master clock of a bit period
    logic sclkLevel;  // divider phase: high half of bit period
  } strobes_t;
endpackage

// File: rtl/sfg_ctrl.sv
module sfg_ctrl #(
  parameter int MULT_BASE = 2,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             powerDown,
  input  logic             frameLong,
  input  logic             slotSel,
  input  logic [SEL_W-1:0] rateSel,
  output logic             cfgLong,
  output logic             cfgSlot,
  output logic [SEL_W-1:0] cfgRate,
  output sfg_pkg::strobes_t strb
);
  localparam int MAX_PERIOD = 2 * MULT_BASE * (2 ** SEL_W);
  localparam int DIV_W      = $clog2(MAX_PERIOD) + 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] kVal;
  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] halfPeriod;
  logic             running;
  logic             lastTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgLong <= frameLong;
      cfgSlot <= slotSel;
      cfgRate <= rateSel;
    end
  end

  always_comb begin
    kVal       = DIV_W'(MULT_BASE) * (DIV_W'(cfgRate) + DIV_W'(1));
    period     = cfgLong ? kVal : (kVal << 1);
    halfPeriod = period >> 1;
  end

  assign running  = !rst && !powerDown;
  assign lastTick = (divCnt == period - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!running) divCnt <= '0;
    else if (lastTick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  always_comb begin
    strb.run       = running;
    strb.clear     = !running;
    strb.bitTick   = running && lastTick;
    strb.sclkLevel = (divCnt >= halfPeriod);
  end
endmodule

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
(
  input  logic             clk,
  input  logic             powerDown,
  input  logic             cfgLong,
  input  logic             cfgSlot,
  input  strobes_t         strb,
  output logic             sclk,
  output logic             ssync,
  output logic             pinEnable,
  output logic             slotActive,
  output logic [IDX_W-1:0] bitIndex,
  output logic             wordRight
);
  localparam int SUB_W  = $clog2(SUB_BITS);
  localparam int WORD_B = $clog2(WORD_BITS);

  logic [IDX_W-1:0] bitCnt;
  logic [IDX_W-1:0] lastBit;
  logic             altSync;

  assign lastBit = cfgLong ? {IDX_W{1'b1}} : IDX_W'(SUB_BITS - 1);
  assign altSync = !cfgLong && cfgSlot;

  always_ff @(posedge clk) begin
    if (strb.clear) bitCnt <= '0;
    else if (strb.bitTick) begin
      if (bitCnt == lastBit) bitCnt <= '0;
      else bitCnt <= bitCnt + IDX_W'(1);
    end
  end

  always_comb begin
    pinEnable  = !powerDown;
    sclk       = strb.run && strb.sclkLevel;
    if (altSync) ssync = strb.run && !bitCnt[WORD_B];
    else         ssync = strb.run && (bitCnt == lastBit);
    slotActive = strb.run && (cfgLong ? (bitCnt[SUB_W] == cfgSlot) : 1'b1);
    wordRight  = strb.run && bitCnt[WORD_B];
    bitIndex   = bitCnt;
  end
endmodule

// File: rtl/serial_frame_sync.sv
module serial_frame_sync #(
  parameter int MULT_BASE = 2,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             powerDown,
  input  logic             frameLong,
  input  logic             slotSel,
  input  logic [SEL_W-1:0] rateSel,
  output logic             sclk,
  output logic             ssync,
  output logic             pinEnable,
  output logic             slotActive,
  output logic [6:0]       bitIndex,
  output logic             wordRight
);
  sfg_pkg::strobes_t strb;
  logic             cfgLong;
  logic             cfgSlot;
  logic [SEL_W-1:0] cfgRate;

  sfg_ctrl #(.MULT_BASE(MULT_BASE), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rst(rst), .powerDown(powerDown),
    .frameLong(frameLong), .slotSel(slotSel), .rateSel(rateSel),
    .cfgLong(cfgLong), .cfgSlot(cfgSlot), .cfgRate(cfgRate), .strb(strb)
  );

  sfg_datapath uPath (
    .clk(clk), .powerDown(powerDown), .cfgLong(cfgLong), .cfgSlot(cfgSlot),
    .strb(strb), .sclk(sclk), .ssync(ssync), .pinEnable(pinEnable),
    .slotActive(slotActive), .bitIndex(bitIndex), .wordRight(wordRight)
  );
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             powerDown,
  input logic             cfgLong,
  input logic             cfgSlot,
  input logic [SEL_W-1:0] cfgRate,
  input logic             sclk,
  input logic             ssync,
  input logic             pinEnable,
  input logic             slotActive,
  input logic [6:0]       bitIndex,
  input logic             wordRight
);
  // R2: the bit index only moves as the bit clock falls
  p_bit_on_fall_r2: assert property (@(posedge clk) disable iff (rst || powerDown)
    (bitIndex != $past(bitIndex)) |-> ($past(sclk) && !sclk));

  // R1: short frames never pass bit 63
  p_short_wrap_r1: assert property (@(posedge clk) disable iff (rst || powerDown)
    !cfgLong |-> (bitIndex < 7'd64));

  // R5: pulse sync only in the last bit of the frame
  p_sync_pulse_r5: assert property (@(posedge clk) disable iff (rst || powerDown)
    (ssync && (cfgLong || !cfgSlot)) |-> (bitIndex == (cfgLong ? 7'd127 : 7'd63)));

  // R6: word-wide sync is the complement of the right-word flag
  p_alt_sync_r6: assert property (@(posedge clk) disable iff (rst || powerDown)
    (!cfgLong && cfgSlot) |-> (ssync == !wordRight));

  // R3: the active half follows the slot choice
  p_slot_half_r3: assert property (@(posedge clk) disable iff (rst || powerDown)
    cfgLong |-> (slotActive == (bitIndex[6] == cfgSlot)));

  // R4: short frames are always active
  p_short_active_r4: assert property (@(posedge clk) disable iff (rst || powerDown)
    !cfgLong |-> slotActive);

  // R9: power-down releases the pins and silences the outputs
  p_pd_release_r9: assert property (@(posedge clk)
    powerDown |-> (!pinEnable && !sclk && !ssync && !slotActive));

  // R8: reset drives the pins low
  p_rst_low_r8: assert property (@(posedge clk)
    (rst && !powerDown) |-> (pinEnable && !sclk && !ssync));

  // R10: configuration holds outside reset
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $stable(cfgRate) && $stable(cfgLong) && $stable(cfgSlot));
endmodule

bind serial_frame_sync sfg_checker #(.SEL_W(SEL_W)) uChecker (
  .clk(clk), .rst(rst), .powerDown(powerDown), .cfgLong(cfgLong),
  .cfgSlot(cfgSlot), .cfgRate(cfgRate), .sclk(sclk), .ssync(ssync),
  .pinEnable(pinEnable), .slotActive(slotActive), .bitIndex(bitIndex),
  .wordRight(wordRight)
);

// File: tb/tb_serial_frame_sync.sv
`timescale 1ns/1ps
module tb_serial_frame_sync;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       powerDown = 1'b0;
  logic       frameLong = 1'b0;
  logic       slotSel = 1'b0;
  logic [2:0] rateSel = 3'd0;
  logic       sclk, ssync, pinEnable, slotActive, wordRight;
  logic [6:0] bitIndex;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic       en;
    logic       sc;
    logic       sy;
    logic       act;
    logic       wr;
    logic [6:0] idx;
    logic       chkIdx;
  } expect_t;

  expect_t expQ[$];

  always #4 clk = ~clk;

  serial_frame_sync dut (
    .clk(clk), .rst(rst), .powerDown(powerDown), .frameLong(frameLong),
    .slotSel(slotSel), .rateSel(rateSel), .sclk(sclk), .ssync(ssync),
    .pinEnable(pinEnable), .slotActive(slotActive), .bitIndex(bitIndex),
    .wordRight(wordRight)
  );

  task automatic checkBit(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expect_t e;
      e = expQ.pop_front();
      checkBit("R8/R9 pinEnable", pinEnable, e.en);
      checkBit("R2 sclk", sclk, e.sc);
      checkBit("R5/R6 ssync", ssync, e.sy);
      checkBit("R3/R4 slotActive", slotActive, e.act);
      checkBit("R7 wordRight", wordRight, e.wr);
      if (e.chkIdx) begin
        testsRun++;
        if (bitIndex !== e.idx) begin
          testsFailed++;
          $display("FAIL R1 bitIndex at %0t: actual %0d expected %0d",
                   $time, bitIndex, e.idx);
        end
      end
    end
  end

  function automatic expect_t runExp(input int c, input bit lng, input bit slt,
                                     input int rate);
    expect_t e;
    int k, p, fb, d, b;
    k  = 2 * (rate + 1);
    p  = lng ? k : 2 * k;
    fb = lng ? 128 : 64;
    d  = c % p;
    b  = (c / p) % fb;
    e.en     = 1'b1;
    e.sc     = (d >= p / 2);
    e.sy     = (!lng && slt) ? (b < 32) : (b == fb - 1);
    e.act    = lng ? ((b >= 64) == slt) : 1'b1;
    e.wr     = ((b % 64) >= 32);
    e.idx    = 7'(b);
    e.chkIdx = 1'b1;
    return e;
  endfunction

  function automatic expect_t stopExp(input bit pd, input bit idxKnown);
    expect_t e;
    e.en = !pd; e.sc = 0; e.sy = 0; e.act = 0; e.wr = 0;
    e.idx = 7'd0; e.chkIdx = idxKnown;
    return e;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // driver: reset with a config, then run; optional mid-run input change (R10)
  task automatic runConfig(input bit lng, input bit slt, input int rate,
                           input int cycles, input int changeAt);
    step();
    rst = 1'b1; frameLong = lng; slotSel = slt; rateSel = 3'(rate);
    expQ.push_back(stopExp(1'b0, 1'b0)); // R8 reset state
    step();
    expQ.push_back(stopExp(1'b0, 1'b1)); // R8 bit index cleared
    step();
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      if (c == changeAt) begin
        frameLong = ~lng; slotSel = ~slt; rateSel = 3'(rate) ^ 3'd5; // R10
      end
      expQ.push_back(runExp(c, lng, slt, rate));
      step();
    end
  endtask

  initial begin
    #(8 * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1 R3 R5: long frames, first slot, fastest rate (period 2)
    runConfig(1'b1, 1'b0, 0, 128 * 2 + 20, -1);
    // R3 R10: long frames, second slot, inputs changed mid-run
    runConfig(1'b1, 1'b1, 1, 128 * 4 + 30, 100);
    // R4 R5: short frames, pulse sync
    runConfig(1'b0, 1'b0, 0, 64 * 4 + 20, -1);
    // R6 R7: short frames, word-wide sync
    runConfig(1'b0, 1'b1, 2, 64 * 12 + 40, 300);
    // R2: slowest rate, short frames, one full frame
    runConfig(1'b0, 1'b0, 7, 64 * 32 + 10, -1);

    // R9: power-down mid-run, then restart from bit 0
    runConfig(1'b1, 1'b1, 0, 50, -1);
    powerDown = 1'b1;
    for (int i = 0; i < 4; i++) begin
      expQ.push_back(stopExp(1'b1, i > 0));
      step();
    end
    // R9: power-down wins over reset
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      expQ.push_back(stopExp(1'b1, 1'b1));
      step();
    end
    rst = 1'b0;
    powerDown = 1'b0;
    for (int c = 0; c < 300; c++) begin
      expQ.push_back(runExp(c, 1'b1, 1'b1, 0));
      step();
    end

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule